// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and a calendar, entirely in packed BCD, and advances one second for each single-cycle tick pulse it receives from an external one-hertz source. The fields are seconds, minutes, hours (24-hour), day of week, date, month, year and century. Carries ripple from seconds up to century in the same clock edge. The block applies month lengths automatically. February follows a simple every-fourth-year leap rule.

Software can preset every field at once through a synchronous load strobe. Four alarm inputs give a date, hour, minute and second. When a tick moves the clock onto a moment that matches all four, the block pulls an active-low interrupt low. The interrupt stays low until software acknowledges it.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read century 0x20, year 0x00, month 0x01, date 0x01, day of week 0x01, and 0x00 for hour, minute and second. `irq_n_o` is high.
- R2: While `load_i` is high, the next edge copies all eight load inputs into the fields. Load takes priority over a simultaneous tick. A load never raises the interrupt, even when the loaded time equals the alarm.
- R3: Each edge with `tick_i` high and `load_i` low advances seconds in BCD from 0x00 to 0x59. Seconds at 0x59 or above become 0x00 and carry into minutes. Without tick or load, every field holds.
- R4: Minutes run 0x00 to 0x59 and carry into hours. Hours run 0x00 to 0x23 and wrap to 0x00 at midnight.
- R5: At midnight both date and day of week advance. Day of week counts 0x01 to 0x07 and then returns to 0x01.
- R6: Months 0x04, 0x06, 0x09 and 0x11 end after date 0x30. February ends after 0x28, or 0x29 in a leap year. Every other month ends after 0x31. After the last date comes date 0x01 of the next month.
- R7: A year is a leap year when its two-digit BCD value is divisible by four, including 0x00.
- R8: Month 0x12 rolls to 0x01 and carries into the year. Year 0x99 rolls to 0x00 and increments the century in BCD. Century 0x99 rolls to 0x00.
- R9: Suppose a tick edge leaves date, hour, minute and second equal to the four alarm inputs. Then `irq_n_o` goes low on the following edge and stays low until it is acknowledged.
- R10: Holding `irq_ack_i` high for an edge releases `irq_n_o` high at that edge. If an alarm match is set on the same edge, the match wins and `irq_n_o` stays low.
- R11: A date loaded at or past the month's last day rolls to 0x01 of the next month at the next midnight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| load_i | input | 1 | Synchronous preset strobe for all fields |
| ld_sec_i | input | 8 | BCD seconds to load |
| ld_min_i | input | 8 | BCD minutes to load |
| ld_hour_i | input | 8 | BCD hours to load |
| ld_dow_i | input | 8 | BCD day of week to load |
| ld_date_i | input | 8 | BCD date to load |
| ld_month_i | input | 8 | BCD month to load |
| ld_year_i | input | 8 | BCD year to load |
| ld_cent_i | input | 8 | BCD century to load |
| alm_sec_i | input | 8 | Alarm second, BCD |
| alm_min_i | input | 8 | Alarm minute, BCD |
| alm_hour_i | input | 8 | Alarm hour, BCD |
| alm_date_i | input | 8 | Alarm date, BCD |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| sec_o | output | 8 | Current seconds, BCD |
| min_o | output | 8 | Current minutes, BCD |
| hour_o | output | 8 | Current hours, BCD |
| dow_o | output | 8 | Current day of week, BCD |
| date_o | output | 8 | Current date, BCD |
| month_o | output | 8 | Current month, BCD |
| year_o | output | 8 | Current year, BCD |
| cent_o | output | 8 | Current century, BCD |
| irq_n_o | output | 1 | Alarm interrupt, active low |

## Verification
Two pairs of functions can coincide on one edge. The first pair is a load and a tick. The bench raises both strobes together and expects the loaded values, not an advanced time. The second pair is a pending alarm match and an acknowledge. The bench lines up a matching tick so that its set edge coincides with `irq_ack_i`, and expects the interrupt to stay low. A behavioural model of the calendar, built on integers, is compared against every field and the interrupt on each cycle. This covers long tick runs across midnight as well as spaced ticks.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
   typedef logic [7:0] bcd8_t;

   localparam bcd8_t LIM_SEC   = 8'h59;
   localparam bcd8_t LIM_MIN   = 8'h59;
   localparam bcd8_t LIM_HOUR  = 8'h23;
   localparam bcd8_t LIM_DOW   = 8'h07;
   localparam bcd8_t LIM_MONTH = 8'h12;
   localparam bcd8_t LIM_YEAR  = 8'h99;
   localparam bcd8_t LIM_CENT  = 8'h99;

   function automatic logic bcd_ok(bcd8_t v);
      return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
   endfunction

   function automatic bcd8_t bcd_inc(bcd8_t v);
      if (v[3:0] >= 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction
endpackage

// File: rtl/cal_bcd_field.sv
`timescale 1ns/1ps
module cal_bcd_field #(
   parameter cal_pkg::bcd8_t MIN_VAL = 8'h00,
   parameter cal_pkg::bcd8_t RST_VAL = 8'h00
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_i,
   input  cal_pkg::bcd8_t ld_val_i,
   input  logic           inc_i,
   input  cal_pkg::bcd8_t lim_i,
   output cal_pkg::bcd8_t val_o,
   output logic           wrap_o
);
   import cal_pkg::*;

   initial begin
      assert (bcd_ok(MIN_VAL) && bcd_ok(RST_VAL))
         else $error("cal_bcd_field: MIN_VAL and RST_VAL must be valid BCD");
   end

   bcd8_t val_q, val_d;
   logic  at_lim;

   assign at_lim = (val_q >= lim_i);
   assign wrap_o = inc_i & ~ld_i & at_lim;
   assign val_o  = val_q;

   always_comb begin
      val_d = val_q;
      if (ld_i)
         val_d = ld_val_i;
      else if (inc_i)
         val_d = at_lim ? MIN_VAL : bcd_inc(val_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= RST_VAL;
      else        val_q <= val_d;
   end

   // R3
   rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !ld_i && (val_o >= lim_i)) |=> (val_o == MIN_VAL));

   // R2
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (val_o == $past(ld_val_i)));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !ld_i) |=> $stable(val_o));
endmodule

// File: rtl/cal_month_len.sv
`timescale 1ns/1ps
module cal_month_len (
   input  cal_pkg::bcd8_t month_i,
   input  cal_pkg::bcd8_t year_i,
   output cal_pkg::bcd8_t last_date_o
);
   logic leap;
   logic [3:0] ones;

   assign ones = year_i[3:0];
   // divisible by four: even tens need ones 0/4/8, odd tens need ones 2/6
   assign leap = year_i[4] ? ((ones == 4'd2) || (ones == 4'd6))
                           : ((ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8));

   always_comb begin
      case (month_i)
         8'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
         default:                    last_date_o = 8'h31;
      endcase
   end
endmodule

// File: rtl/cal_alarm_latch.sv
`timescale 1ns/1ps
module cal_alarm_latch #(
   parameter int LANES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       adv_i,
   input  cal_pkg::bcd8_t [LANES-1:0] now_i,
   input  cal_pkg::bcd8_t [LANES-1:0] alm_i,
   input  logic                       ack_i,
   output logic                       irq_n_o
);
   initial begin
      assert (LANES >= 1) else $error("cal_alarm_latch: LANES must be at least 1");
   end

   logic [LANES-1:0] lane_eq;
   logic adv_q, hit, flag_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_eq[g] = (now_i[g] == alm_i[g]);
   end

   assign hit     = adv_q & (&lane_eq);
   assign irq_n_o = ~flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adv_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         adv_q <= adv_i;
         if (hit)        flag_q <= 1'b1;
         else if (ack_i) flag_q <= 1'b0;
      end
   end

   // R10
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !hit) |=> irq_n_o);

   // R9
   sticky_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n_o && !ack_i) |=> !irq_n_o);

   // R9
   fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n_o) |-> $past(adv_q));
endmodule

// File: rtl/bcd_calendar_core.sv
`timescale 1ns/1ps
module bcd_calendar_core #(
   parameter logic [7:0] RST_CENT  = 8'h20,
   parameter logic [7:0] RST_YEAR  = 8'h00,
   parameter logic [7:0] RST_MONTH = 8'h01,
   parameter logic [7:0] RST_DATE  = 8'h01,
   parameter logic [7:0] RST_DOW   = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       load_i,
   input  logic [7:0] ld_sec_i,
   input  logic [7:0] ld_min_i,
   input  logic [7:0] ld_hour_i,
   input  logic [7:0] ld_dow_i,
   input  logic [7:0] ld_date_i,
   input  logic [7:0] ld_month_i,
   input  logic [7:0] ld_year_i,
   input  logic [7:0] ld_cent_i,
   input  logic [7:0] alm_sec_i,
   input  logic [7:0] alm_min_i,
   input  logic [7:0] alm_hour_i,
   input  logic [7:0] alm_date_i,
   input  logic       irq_ack_i,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] dow_o,
   output logic [7:0] date_o,
   output logic [7:0] month_o,
   output logic [7:0] year_o,
   output logic [7:0] cent_o,
   output logic       irq_n_o
);
   import cal_pkg::*;

   localparam int ALARM_LANES = 4;

   initial begin
      assert (bcd_ok(RST_CENT) && bcd_ok(RST_YEAR))
         else $error("bcd_calendar_core: reset century/year must be BCD");
      assert ((RST_MONTH >= 8'h01) && (RST_MONTH <= LIM_MONTH) && (RST_DATE >= 8'h01)
              && (RST_DOW >= 8'h01) && (RST_DOW <= LIM_DOW))
         else $error("bcd_calendar_core: reset month/date/day out of range");
   end

   logic  adv;
   logic  sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap, year_wrap;
   logic  dow_carry_unused, cent_carry_unused;
   bcd8_t last_date;

   assign adv = tick_i & ~load_i;

   cal_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00)) u_sec (
      .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ld_val_i(ld_sec_i),
      .inc_i(adv), .lim_i(LIM_SEC), .val_o(sec_o), .wrap_o(sec_wrap));

   cal_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00)) u_min (
      .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ld_val_i(ld_min_i),
      .inc_i(sec_wrap), .lim_i(LIM_MIN), .val_o(min_o), .wrap_o(min_wrap));

   cal_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00)) u_hour (
      .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ld_val_i(ld_hour_i),
      .inc_i(min_wrap), .lim_i(LIM_HOUR), .val_o(hour_o), .wrap_o(hour_wrap));

   cal_bcd_field #(.MIN_VAL(8'h01), .RST_VAL(RST_DOW)) u_dow (
      .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ld_val_i(ld_dow_i),
      .inc_i(hour_wrap), .lim_i(LIM_DOW), .val_o(dow_o), .wrap_o(dow_carry_unused));

   cal_month_len u_mlen (
      .month_i(month_o), .year_i(year_o), .last_date_o(last_date));

   cal_bcd_field #(.MIN_VAL(8'h01), .RST_VAL(RST_DATE)) u_date (
      .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ld_val_i(ld_date_i),
      .inc_i(hour_wrap), .lim_i(last_date), .val_o(date_o), .wrap_o(date_wrap));

   cal_bcd_field #(.MIN_VAL(8'h01), .RST_VAL(RST_MONTH)) u_month (
      .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ld_val_i(ld_month_i),
      .inc_i(date_wrap), .lim_i(LIM_MONTH), .val_o(month_o), .wrap_o(month_wrap));

   cal_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(RST_YEAR)) u_year (
      .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ld_val_i(ld_year_i),
      .inc_i(month_wrap), .lim_i(LIM_YEAR), .val_o(year_o), .wrap_o(year_wrap));

   cal_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(RST_CENT)) u_cent (
      .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ld_val_i(ld_cent_i),
      .inc_i(year_wrap), .lim_i(LIM_CENT), .val_o(cent_o), .wrap_o(cent_carry_unused));

   cal_alarm_latch #(.LANES(ALARM_LANES)) u_alarm (
      .clk(clk), .rst_n(rst_n), .adv_i(adv),
      .now_i({date_o, hour_o, min_o, sec_o}),
      .alm_i({alm_date_i, alm_hour_i, alm_min_i, alm_sec_i}),
      .ack_i(irq_ack_i), .irq_n_o(irq_n_o));

   // R4
   min_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i && (sec_o < 8'h59)) |=> $stable(min_o));

   // R5
   midnight_date_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && hour_o == 8'h23 && min_o == 8'h59 && sec_o == 8'h59) |=> !$stable(date_o));

   // R2
   load_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && irq_n_o && !$past(adv)) |=> irq_n_o);
endmodule

// File: tb/bcd_calendar_core_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_core_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, load = 1'b0, ack = 1'b0;
   logic [7:0] l_sec = 0, l_min = 0, l_hour = 0, l_dow = 8'h01, l_date = 8'h01;
   logic [7:0] l_month = 8'h01, l_year = 0, l_cent = 8'h20;
   logic [7:0] a_sec = 8'h45, a_min = 8'h30, a_hour = 8'h12, a_date = 8'h15;
   logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o;
   logic irq_n_o;

   int ntest = 0, nfail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bcd_calendar_core dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load),
      .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hour), .ld_dow_i(l_dow),
      .ld_date_i(l_date), .ld_month_i(l_month), .ld_year_i(l_year), .ld_cent_i(l_cent),
      .alm_sec_i(a_sec), .alm_min_i(a_min), .alm_hour_i(a_hour), .alm_date_i(a_date),
      .irq_ack_i(ack),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
      .month_o(month_o), .year_o(year_o), .cent_o(cent_o), .irq_n_o(irq_n_o));

   function automatic int from_bcd(logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic [7:0] to_bcd(int v);
      return 8'(((v / 10) * 16) + (v % 10));
   endfunction

   function automatic int mdays(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   // behavioural reference model
   int s, m, h, dw, d, mo, y, c;
   bit flag, pend;

   always @(posedge clk) begin
      if (!rst_n) begin
         s = 0; m = 0; h = 0; dw = 1; d = 1; mo = 1; y = 0; c = 20;
         flag = 0; pend = 0;
      end else begin
         if (pend) flag = 1;
         else if (ack) flag = 0;
         pend = 0;
         if (load) begin
            s = from_bcd(l_sec); m = from_bcd(l_min); h = from_bcd(l_hour);
            dw = from_bcd(l_dow); d = from_bcd(l_date); mo = from_bcd(l_month);
            y = from_bcd(l_year); c = from_bcd(l_cent);
         end else if (tick) begin
            if (s < 59) s++;
            else begin
               s = 0;
               if (m < 59) m++;
               else begin
                  m = 0;
                  if (h < 23) h++;
                  else begin
                     h = 0;
                     dw = (dw >= 7) ? 1 : dw + 1;
                     if (d < mdays(mo, y)) d++;
                     else begin
                        d = 1;
                        if (mo < 12) mo++;
                        else begin
                           mo = 1;
                           if (y < 99) y++;
                           else begin
                              y = 0;
                              c = (c >= 99) ? 0 : c + 1;
                           end
                        end
                     end
                  end
               end
            end
            pend = (d == from_bcd(a_date)) && (h == from_bcd(a_hour)) &&
                   (m == from_bcd(a_min)) && (s == from_bcd(a_sec));
         end
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      ntest++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act %h exp %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R3 seconds", sec_o, to_bcd(s));
      chk("R4 minutes", min_o, to_bcd(m));
      chk("R4 hours", hour_o, to_bcd(h));
      chk("R5 day of week", dow_o, to_bcd(dw));
      chk("R6 date", date_o, to_bcd(d));
      chk("R8 month", month_o, to_bcd(mo));
      chk("R8 year", year_o, to_bcd(y));
      chk("R8 century", cent_o, to_bcd(c));
      chk("R9 irq_n", {7'd0, irq_n_o}, {7'd0, ~flag});
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
   endtask

   task automatic pulse(int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; cyc(); tick = 1'b0;
      end
   endtask

   task automatic do_load(logic [7:0] cc, yy, mm, dd, ww, hh, mi, ss);
      l_cent = cc; l_year = yy; l_month = mm; l_date = dd;
      l_dow = ww; l_hour = hh; l_min = mi; l_sec = ss;
      load = 1'b1; cyc(); load = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R1 watchdog expired act 0 exp 1");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 century", cent_o, 8'h20);
      chk("R1 year", year_o, 8'h00);
      chk("R1 month", month_o, 8'h01);
      chk("R1 date", date_o, 8'h01);
      chk("R1 dow", dow_o, 8'h01);
      chk("R1 hms", hour_o | min_o | sec_o, 8'h00);
      chk("R1 irq_n", {7'd0, irq_n_o}, 8'h01);

      // R3 idle holds, spaced ticks
      repeat (4) cyc();
      for (int i = 0; i < 150; i++) begin
         tick = (i % 3 == 0); cyc();
      end
      tick = 1'b0;

      // R6 R7 non-leap February, R5 dow wrap
      do_load(8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
      pulse(2);
      chk("R7 non-leap Feb ends at 28", date_o, 8'h01);
      chk("R6 month after Feb", month_o, 8'h03);
      chk("R5 dow 7 wraps to 1", dow_o, 8'h01);

      // R7 leap year
      do_load(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      pulse(1);
      chk("R7 leap Feb has 29", date_o, 8'h29);
      do_load(8'h21, 8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      pulse(1);
      chk("R7 year 00 is leap", date_o, 8'h29);

      // R6 thirty-day month
      do_load(8'h20, 8'h25, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
      pulse(1);
      chk("R6 April ends at 30", month_o, 8'h05);
      do_load(8'h20, 8'h25, 8'h05, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
      pulse(1);
      chk("R6 May has 31", date_o, 8'h31);

      // R11 date loaded past month end
      do_load(8'h20, 8'h25, 8'h04, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
      pulse(1);
      chk("R11 oversize date rolls", date_o, 8'h01);
      chk("R11 month advances", month_o, 8'h05);

      // R8 year and century rollover
      do_load(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
      pulse(1);
      chk("R8 century increments", cent_o, 8'h21);
      chk("R8 year wraps", year_o, 8'h00);
      chk("R8 month wraps", month_o, 8'h01);
      do_load(8'h99, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
      pulse(1);
      chk("R8 century 99 wraps", cent_o, 8'h00);

      // R4 long run across midnight
      do_load(8'h20, 8'h00, 8'h01, 8'h31, 8'h04, 8'h23, 8'h00, 8'h00);
      pulse(3700);
      chk("R4 hour after midnight", hour_o, 8'h00);

      // R9 alarm
      a_date = 8'h01; a_hour = 8'h00; a_min = 8'h00; a_sec = 8'h05;
      do_load(8'h20, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
      pulse(5);
      chk("R9 irq not before set edge", {7'd0, irq_n_o}, 8'h01);
      cyc();
      chk("R9 irq low after match", {7'd0, irq_n_o}, 8'h00);
      repeat (5) cyc();
      chk("R9 irq sticky", {7'd0, irq_n_o}, 8'h00);
      pulse(3);
      chk("R9 irq sticky over ticks", {7'd0, irq_n_o}, 8'h00);

      // R10 acknowledge
      ack = 1'b1; cyc(); ack = 1'b0;
      chk("R10 ack releases", {7'd0, irq_n_o}, 8'h01);

      // R10 coincident set and ack
      a_sec = 8'h09;
      pulse(1);
      ack = 1'b1; cyc(); ack = 1'b0;
      chk("R10 set wins over ack", {7'd0, irq_n_o}, 8'h00);
      ack = 1'b1; cyc(); ack = 1'b0;
      chk("R10 ack later releases", {7'd0, irq_n_o}, 8'h01);

      // R2 load matching alarm raises nothing
      do_load(8'h20, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h09);
      cyc();
      chk("R2 load does not alarm", {7'd0, irq_n_o}, 8'h01);

      // R2 load beats tick
      tick = 1'b1;
      do_load(8'h20, 8'h30, 8'h07, 8'h14, 8'h02, 8'h11, 8'h22, 8'h33);
      tick = 1'b0;
      chk("R2 load over tick sec", sec_o, 8'h33);
      chk("R2 load over tick min", min_o, 8'h22);
      chk("R2 load year", year_o, 8'h30);

      repeat (3) cyc();
      done = 1;
      summary();
      $finish;
   end
endmodule